// File: doc/BRIEF.md
# Ethernet Receive Pad Trimmer with FCS Check

This block sits in the receive path of an Ethernet MAC, after the preamble and start-of-frame delimiter have been removed upstream. It accepts one frame as a byte stream, with a start flag on the first destination-address byte and an end flag on the last FCS byte. It captures the two-byte Length/Type field and, when trimming is enabled and that field holds a short 802.3 length, it forwards only the real data bytes and drops the pad bytes that follow them.

The block runs a CRC-32 over every byte it receives, pad and FCS included. The last four bytes of each frame are held back by a four-byte delay line, so they never reach the output. When a frame ends, the block pulses a done flag for one cycle and presents a status byte that carries the FCS result, together with the captured Length/Type value. Frames whose field holds 46 or more, including any Ethernet type code, pass through untouched apart from losing their FCS. When trimming is disabled, every frame passes this way.

Top module: `eth_rx_pad_trim`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `out_valid` and `frame_done` are 0.
- R2: Bytes 12 and 13 of a frame (counting from 0 at the start-flagged byte) form the Length/Type value, byte 12 being the most significant. From the cycle `frame_done` pulses, `len_type` holds that value.
- R3: With `strip_en` high and a Length/Type value L from 1 to 45, exactly 14+L bytes are forwarded: the header and the first L data bytes. Pad bytes are never forwarded.
- R4: With `strip_en` high and a value of 0 or of 46 and above (which includes every Ethernet type code), all bytes except the last four are forwarded.
- R5: With `strip_en` low, all bytes except the last four are forwarded, whatever the Length/Type value.
- R6: Forwarded bytes keep their order and value. A byte is forwarded only once at least four later bytes of the same frame have arrived, so the four FCS bytes never appear on the output.
- R7: The CRC-32 (polynomial 0x04C11DB7, preset all ones, bits taken LSB first) covers every received byte, pad included. `frame_stat` bit 4 is 1 when the residue after the last byte is not the good-frame value, and 0 otherwise. All other bits of `frame_stat` are 0.
- R8: `frame_done` pulses for exactly one cycle, on the cycle after the end-flagged byte is accepted.
- R9: A start-flagged byte begins a new frame: it restarts the byte count and the CRC, and it discards any bytes still held from an unfinished frame.
- R10: Cycles with `in_valid` low change nothing. Each forwarded byte appears on the cycle after the input byte that pushes it out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_en | input | 1 | Enables pad trimming; sampled when byte 13 arrives |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Forwarded byte is valid |
| out_data | output | 8 | Forwarded byte |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |
| frame_stat | output | 8 | Frame status; bit 4 set on FCS error |
| len_type | output | 16 | Length/Type value of the latest frame |

## Verification
On every cycle, the assertions check the quiet output during reset, that each forwarded byte follows an accepted input byte, that no output appears before five bytes of the frame have arrived, that a trimmed frame never forwards past its stated length, and that each done pulse follows an end-flagged byte. Only the bench's frames can show that the forwarded bytes are the right ones in the right order, that the byte counts match each Length/Type case, and that the FCS verdict is right when a pad byte is corrupted. The same holds for how a restarted or reset frame behaves, and for idle gaps inside a frame.

// File: rtl/eth_rx_pad_trim.sv
module eth_rx_pad_trim #(
  parameter int CNT_W   = 11,
  parameter int HDR_LEN = 14,
  parameter int MIN_PAY = 46
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strip_en,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        frame_done,
  output logic [7:0]  frame_stat,
  output logic [15:0] len_type
);
  localparam int          DLY      = 4;
  localparam int          LEN_HI   = HDR_LEN - 2;
  localparam int          LEN_LO   = HDR_LEN - 1;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_GOOD = 32'hDEBB20E3;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  logic [CNT_W-1:0] cnt, pos, out_cnt;
  logic [7:0]       len_hi;
  logic [15:0]      len_q;
  logic             trim_q, fcs_err;
  logic [31:0]      crc, crc_nx;
  logic [7:0]       pipe_d [DLY];
  logic [DLY-1:0]   pipe_k;
  logic [2:0]       fill;
  logic             keep;
  logic [15:0]      len_now;

  assign pos     = in_sof ? '0 : cnt;
  assign crc_nx  = crc_step(in_sof ? 32'hFFFFFFFF : crc, in_data);
  assign len_now = {len_hi, in_data};
  assign keep    = !(trim_q && (16'(pos) >= 16'(HDR_LEN) + len_q));

  assign frame_stat = {3'b000, fcs_err, 4'b0000};
  assign len_type   = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      len_hi     <= '0;
      len_q      <= '0;
      trim_q     <= 1'b0;
      crc        <= '1;
      fill       <= '0;
      pipe_k     <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      frame_done <= 1'b0;
      fcs_err    <= 1'b0;
    end else begin
      out_valid  <= 1'b0;
      frame_done <= 1'b0;
      if (in_valid) begin
        cnt <= (pos == '1) ? pos : pos + 1'b1;
        crc <= crc_nx;
        if (in_sof) trim_q <= 1'b0;
        if (pos == CNT_W'(LEN_HI)) len_hi <= in_data;
        if (pos == CNT_W'(LEN_LO)) begin
          len_q  <= len_now;
          trim_q <= strip_en && (len_now != 16'd0) && (len_now < 16'(MIN_PAY));
        end
        pipe_d[0] <= in_data;
        pipe_k    <= {pipe_k[DLY-2:0], keep};
        if (!in_sof && fill == 3'(DLY) && pipe_k[DLY-1]) begin
          out_valid <= 1'b1;
          out_data  <= pipe_d[DLY-1];
        end
        if (in_eof) begin
          fill       <= '0;
          frame_done <= 1'b1;
          fcs_err    <= (crc_nx != CRC_GOOD);
        end else if (in_sof) begin
          fill <= 3'd1;
        end else if (fill != 3'(DLY)) begin
          fill <= fill + 3'd1;
        end
      end
    end
  end

  for (genvar g = 1; g < DLY; g++) begin : g_pipe
    always_ff @(posedge clk)
      if (in_valid) pipe_d[g] <= pipe_d[g-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   out_cnt <= '0;
    else if (in_valid && in_sof)  out_cnt <= '0;
    else if (out_valid)           out_cnt <= out_cnt + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!out_valid && !frame_done)); // R1
  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid)); // R10
  AST_FCS_HELD: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (cnt >= CNT_W'(DLY + 1))); // R6
  AST_TRIM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && trim_q) |-> (16'(out_cnt) < 16'(HDR_LEN) + len_q)); // R3
  AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> $past(in_valid && in_eof)); // R8
endmodule

// File: tb/test_eth_rx_pad_trim.sv
module test_eth_rx_pad_trim;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strip_en = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_valid, frame_done;
  logic [7:0]  out_data, frame_stat;
  logic [15:0] len_type;

  always #2 clk = ~clk;

  eth_rx_pad_trim i_eth_rx_pad_trim (
    .clk(clk), .rst_n(rst_n), .strip_en(strip_en), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .frame_done(frame_done), .frame_stat(frame_stat),
    .len_type(len_type));

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] tx [0:2047];
  logic [7:0] rx [0:2047];
  int rx_n = 0, done_n = 0;
  logic [7:0]  stat_cap;
  logic [15:0] lt_cap;

  // strip | len(16) | data bytes(11) | corrupt | expected forwarded bytes(11)
  localparam logic [39:0] VEC [10] = '{
    {1'b1, 16'd10,     11'd46,  1'b0, 11'd24},
    {1'b1, 16'd1,      11'd46,  1'b0, 11'd15},
    {1'b1, 16'd45,     11'd46,  1'b0, 11'd59},
    {1'b1, 16'd46,     11'd46,  1'b0, 11'd60},
    {1'b1, 16'h0800,   11'd46,  1'b0, 11'd60},
    {1'b0, 16'd10,     11'd46,  1'b0, 11'd60},
    {1'b1, 16'd10,     11'd46,  1'b1, 11'd24},
    {1'b1, 16'd100,    11'd100, 1'b0, 11'd114},
    {1'b1, 16'd0,      11'd46,  1'b0, 11'd60},
    {1'b0, 16'h86DD,   11'd60,  1'b1, 11'd74}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_up();
    end
  end

  always @(negedge clk) begin
    if (out_valid) begin
      rx[rx_n] = out_data;
      rx_n++;
    end
    if (frame_done) begin
      done_n++;
      stat_cap = frame_stat;
      lt_cap   = len_type;
    end
  end

  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ tx[i][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return ~c;
  endfunction

  task automatic build(input logic [15:0] len, input int dlen, input bit bad, input int seed, output int n);
    logic [31:0] f;
    n = 14 + dlen + 4;
    for (int i = 0; i < 6; i++)  tx[i] = 8'(8'h10 + i + seed);
    for (int i = 6; i < 12; i++) tx[i] = 8'(8'hA0 + i);
    tx[12] = len[15:8];
    tx[13] = len[7:0];
    for (int j = 0; j < dlen; j++) tx[14+j] = 8'(j * 37 + seed * 5 + 3);
    f = ref_fcs(n - 4);
    for (int k = 0; k < 4; k++) tx[n-4+k] = f[8*k +: 8];
    if (bad) tx[n-5] = tx[n-5] ^ 8'h01;
  endtask

  task automatic drive(input int n, input bit last, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = last && (i == n - 1); in_data = tx[i];
      if (gap != 0 && (i % gap) == 2) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'hEE;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
  endtask

  task automatic run_frame(input bit s, input logic [15:0] len, input int dlen, input bit bad,
                           input int exp, input int gap, input int seed, input string tag);
    int n, mism;
    build(len, dlen, bad, seed, n);
    rx_n = 0; done_n = 0; strip_en = s;
    drive(n, 1'b1, gap);
    repeat (3) @(negedge clk);
    chk(rx_n == exp, {tag, " byte count"}, rx_n, exp);
    mism = 0;
    for (int i = 0; i < exp && i < rx_n; i++) if (rx[i] !== tx[i]) mism++;
    chk(mism == 0, "R6 byte order/value", mism, 0);
    chk(done_n == 1, "R8 done pulses", done_n, 1);
    chk(stat_cap == (bad ? 8'h10 : 8'h00), "R7 fcs status", stat_cap, bad ? 8'h10 : 8'h00);
    chk(lt_cap == len, "R2 length/type", lt_cap, len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(frame_done == 1'b0, "R1 frame_done in reset", frame_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

    for (int v = 0; v < 10; v++) begin
      logic [39:0] e;
      e = VEC[v];
      run_frame(e[39], e[38:23], int'(e[22:12]), e[11], int'(e[10:0]), 0, v,
                e[39] ? ((e[38:23] != 0 && e[38:23] < 46) ? "R3" : "R4") : "R5");
    end

    // R10: idle gaps inside a trimmed frame
    run_frame(1'b1, 16'd20, 46, 1'b0, 34, 5, 11, "R10 gaps");

    // R9: abandoned frame, then a fresh start
    build(16'd30, 46, 1'b0, 12, checks_dummy_n);
    drive(25, 1'b0, 0);
    repeat (2) @(negedge clk);
    run_frame(1'b1, 16'd30, 46, 1'b0, 44, 0, 13, "R9 restart");

    // R1: reset in the middle of a frame
    build(16'd5, 46, 1'b0, 14, checks_dummy_n);
    drive(30, 1'b0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && frame_done == 1'b0, "R1 mid-frame reset", out_valid, 0);
    rst_n = 1'b1;
    run_frame(1'b1, 16'd5, 46, 1'b0, 19, 0, 15, "R3 after reset");

    // R5 with a bad FCS and strip disabled on short frame
    run_frame(1'b0, 16'd3, 46, 1'b1, 60, 0, 16, "R5 bad fcs");
    finish_up();
  end

  int checks_dummy_n;
endmodule